// File: doc/BRIEF.md
# Byte-Serial Egress Frame Editor

This block edits one outgoing frame at a time as it passes through, one byte per clock. Before a frame arrives, earlier match-action stages load a short list of edit commands and a buffer of operand bytes. The engine then works through the list while the frame streams in. Each command can copy input bytes, insert operand bytes, drop input bytes, replace input bytes with operands, decrement a byte (for hop-limit style fields), or replace a two-byte checksum with precomputed operand bytes. The engine does not compute the commands or the operands.

Input and output are byte streams with first-byte and last-byte markers. Both use valid/ready flow control. While the engine inserts bytes, it holds input ready low. It keeps the last emitted byte in a one-entry holding stage. Because of this, the last-byte marker can move back onto the final emitted byte when the frame's own last byte is dropped. Once all commands have run, the rest of the frame passes through unchanged.

Top module: `egress_editor`

## Requirements
- R1: After reset, out_valid is low, and in_ready is high while in_sof is low.
- R2: A command byte holds its opcode in bits [7:5] and a repeat count in bits [4:0]. A count of 0 means one byte. Opcodes: 0 copy, 1 insert, 2 drop, 3 replace, 4 decrement, 5 checksum. Opcodes 6 and 7 act as copy.
- R3: Copy passes the given number of input bytes to the output unchanged.
- R4: Insert emits the given number of operand bytes, consumes no input, and holds in_ready low for every insert cycle.
- R5: Drop consumes the given number of input bytes and emits nothing for them.
- R6: Replace emits one operand byte in place of each of the given number of input bytes.
- R7: Decrement emits each input byte minus one, and an input of 0x00 gives 0x00.
- R8: Checksum replaces exactly the next two input bytes with the next two operands. Its count field is ignored.
- R9: Operands are taken in order through one pointer that restarts at operand 0 on each frame. Any operand at index 56 or above reads as 0x00.
- R10: After the programmed number of commands has run, the rest of the frame is copied unchanged. Commands that have not run when the input last byte is consumed are discarded.
- R11: out_sof marks the first emitted byte and out_eof the last one, including when the input last byte was dropped. A frame whose bytes are all dropped produces no output.
- R12: While out_valid is high and out_ready is low, out_valid, out_data, out_sof and out_eof hold their values.
- R13: While no frame is open, input bytes without in_sof are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd_we | input | 1 | Write strobe for a command byte |
| cfg_cmd_addr | input | 5 | Command list index |
| cfg_cmd_data | input | 8 | Command byte |
| cfg_len_we | input | 1 | Write strobe for the command count |
| cfg_len | input | 5 | Number of commands to run per frame |
| cfg_opr_we | input | 1 | Write strobe for an operand byte |
| cfg_opr_addr | input | 6 | Operand index |
| cfg_opr_data | input | 8 | Operand byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |

## Verification
The command decision is made in the same cycle as the input handshake. Stall results are therefore due at once: the bench samples in_ready one time unit after each falling edge. In the insert-stall case it expects ready low for exactly the first four cycles after a frame is presented. Emitted bytes leave through two registers, and a byte is released only when the next byte is produced or the frame ends. For that reason, output bytes are compared in transfer order against a stream computed from the requirements, not at fixed cycle offsets. The last byte is due one cycle after the input last byte is consumed. Held-output checks compare each stalled cycle with the next one.

// File: rtl/egm_pkg.sv
package egm_pkg;

  typedef enum logic [2:0] {
    OP_COPY    = 3'd0,
    OP_INSERT  = 3'd1,
    OP_DROP    = 3'd2,
    OP_REPLACE = 3'd3,
    OP_DECR    = 3'd4,
    OP_CSUM    = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } edit_op_e;

  typedef struct packed {
    edit_op_e   op;
    logic [4:0] reps;
  } edit_cmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;

  function automatic logic [7:0] sat_dec(input logic [7:0] b);
    return (b == 8'h00) ? 8'h00 : b - 8'h01;
  endfunction

endpackage

// File: rtl/egm_regfile.sv
module egm_regfile #(
  parameter int DEPTH = 20,
  parameter int AW    = 5,
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0] rd_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic         hit;
    logic [W-1:0] ent_q;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) ent_q <= wdata;
    end
    assign rd_tab[g] = ent_q;
  end

  always_comb begin
    rdata = '0;
    if (raddr <= LAST_IDX) rdata = rd_tab[raddr];
  end

endmodule

// File: rtl/egm_exec.sv
module egm_exec
  import egm_pkg::*;
#(
  parameter int CIW = 5,
  parameter int OPW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           len_we,
  input  logic [CIW-1:0] len_wdata,
  output logic [CIW-1:0] cmd_idx,
  input  edit_cmd_t      cmd_word,
  output logic [OPW-1:0] opr_ptr,
  input  logic [7:0]     opr_byte,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  input  logic           in_sof,
  input  logic           in_eof,
  output logic           in_ready,
  input  logic           push_ok,
  output logic           push,
  output logic [7:0]     push_data,
  output logic           push_sof,
  output logic           push_eof,
  output logic           mark
);

  run_st_e        st_q, st_d;
  logic [CIW-1:0] idx_q, idx_d, len_q, len_d;
  logic [4:0]     rep_q, rep_d;
  logic [OPW-1:0] ptr_q, ptr_d;
  logic           first_q, first_d;

  logic           live, needs_in, emits, uses_opr, fire;
  edit_op_e       cur_op;
  logic [4:0]     last_rep;

  // command decode
  always_comb begin
    live   = (st_q == ST_RUN) && (idx_q < len_q);
    cur_op = OP_COPY;
    if (live) begin
      case (cmd_word.op)
        OP_RSV6, OP_RSV7: cur_op = OP_COPY;
        default:          cur_op = cmd_word.op;
      endcase
    end
    if (cur_op == OP_CSUM)          last_rep = 5'd1;
    else if (cmd_word.reps == 5'd0) last_rep = 5'd0;
    else                            last_rep = cmd_word.reps - 5'd1;
    needs_in = (cur_op != OP_INSERT);
    emits    = (cur_op != OP_DROP);
    uses_opr = (cur_op == OP_INSERT) || (cur_op == OP_REPLACE) || (cur_op == OP_CSUM);
  end

  // handshake and emitted byte
  always_comb begin
    if (st_q == ST_IDLE) in_ready = !in_sof;
    else                 in_ready = needs_in && (!emits || push_ok);
    fire = (st_q == ST_RUN) && (needs_in ? (in_valid && in_ready) : push_ok);
    push = fire && emits;
    case (cur_op)
      OP_INSERT, OP_REPLACE, OP_CSUM: push_data = opr_byte;
      OP_DECR:                        push_data = sat_dec(in_data);
      default:                        push_data = in_data;
    endcase
    push_sof = first_q;
    push_eof = needs_in && in_eof;
    mark     = fire && !emits && in_eof;
  end

  // next state
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    rep_d   = rep_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    len_d   = len_we ? len_wdata : len_q;
    case (st_q)
      ST_IDLE: begin
        if (in_valid && in_sof) begin
          st_d    = ST_RUN;
          idx_d   = '0;
          rep_d   = '0;
          ptr_d   = '0;
          first_d = 1'b1;
        end
      end
      default: begin
        if (fire) begin
          if (uses_opr && (ptr_q != '1)) ptr_d = ptr_q + 1'b1;
          if (push) first_d = 1'b0;
          if (live) begin
            if (rep_q == last_rep) begin
              idx_d = idx_q + 1'b1;
              rep_d = '0;
            end else begin
              rep_d = rep_q + 5'd1;
            end
          end
          if (needs_in && in_eof) st_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      rep_q   <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      len_q   <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      rep_q   <= rep_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      len_q   <= len_d;
    end
  end

  assign cmd_idx = idx_q;
  assign opr_ptr = ptr_q;

endmodule

// File: rtl/egm_out_stage.sv
module egm_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       push_sof,
  input  logic       push_eof,
  input  logic       mark,
  output logic       push_ok,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);

  logic       h_vld_q, h_vld_d, h_eof_q, h_eof_d, h_sof_q;
  logic [7:0] h_data_q;
  logic       o_vld_q, o_vld_d, o_sof_q, o_eof_q;
  logic [7:0] o_data_q;
  logic       o_free, h_move;

  always_comb begin
    o_free  = !o_vld_q || out_ready;
    h_move  = h_vld_q && o_free && (h_eof_q || push);
    push_ok = !h_vld_q || o_free;

    o_vld_d = o_vld_q;
    if (h_move)         o_vld_d = 1'b1;
    else if (out_ready) o_vld_d = 1'b0;

    h_vld_d = h_vld_q;
    h_eof_d = h_eof_q;
    if (push) begin
      h_vld_d = 1'b1;
      h_eof_d = push_eof;
    end else if (h_move) begin
      h_vld_d = 1'b0;
    end else if (mark && h_vld_q && !h_eof_q) begin
      h_eof_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld_q <= 1'b0;
      h_eof_q <= 1'b0;
      o_vld_q <= 1'b0;
    end else begin
      h_vld_q <= h_vld_d;
      h_eof_q <= h_eof_d;
      o_vld_q <= o_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      h_data_q <= push_data;
      h_sof_q  <= push_sof;
    end
    if (h_move) begin
      o_data_q <= h_data_q;
      o_sof_q  <= h_sof_q;
      o_eof_q  <= h_eof_q;
    end
  end

  assign out_valid = o_vld_q;
  assign out_data  = o_data_q;
  assign out_sof   = o_sof_q;
  assign out_eof   = o_eof_q;

endmodule

// File: rtl/egress_editor.sv
module egress_editor
  import egm_pkg::*;
#(
  parameter int CMD_DEPTH = 20,
  parameter int OPR_DEPTH = 56,
  localparam int CIW = $clog2(CMD_DEPTH + 1),
  localparam int OAW = $clog2(OPR_DEPTH),
  localparam int OPW = OAW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_cmd_we,
  input  logic [CIW-1:0] cfg_cmd_addr,
  input  logic [7:0]     cfg_cmd_data,
  input  logic           cfg_len_we,
  input  logic [CIW-1:0] cfg_len,
  input  logic           cfg_opr_we,
  input  logic [OAW-1:0] cfg_opr_addr,
  input  logic [7:0]     cfg_opr_data,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_sof,
  input  logic           in_eof,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_sof,
  output logic           out_eof
);

  logic [1:0]     rs_q;
  logic           rst_sync_n;
  logic [CIW-1:0] cmd_idx;
  logic [7:0]     cmd_raw;
  edit_cmd_t      cmd_word;
  logic [OPW-1:0] opr_ptr;
  logic [7:0]     opr_byte;
  logic           push_ok, push, push_sof, push_eof, mark;
  logic [7:0]     push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  egm_regfile #(.DEPTH(CMD_DEPTH), .AW(CIW), .W(8)) u_cmds (
    .clk   (clk),
    .we    (cfg_cmd_we),
    .waddr (cfg_cmd_addr),
    .wdata (cfg_cmd_data),
    .raddr (cmd_idx),
    .rdata (cmd_raw)
  );
  assign cmd_word = edit_cmd_t'(cmd_raw);

  egm_regfile #(.DEPTH(OPR_DEPTH), .AW(OPW), .W(8)) u_oprs (
    .clk   (clk),
    .we    (cfg_opr_we),
    .waddr ({1'b0, cfg_opr_addr}),
    .wdata (cfg_opr_data),
    .raddr (opr_ptr),
    .rdata (opr_byte)
  );

  egm_exec #(.CIW(CIW), .OPW(OPW)) u_exec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .len_we    (cfg_len_we),
    .len_wdata (cfg_len),
    .cmd_idx   (cmd_idx),
    .cmd_word  (cmd_word),
    .opr_ptr   (opr_ptr),
    .opr_byte  (opr_byte),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_ready  (in_ready),
    .push_ok   (push_ok),
    .push      (push),
    .push_data (push_data),
    .push_sof  (push_sof),
    .push_eof  (push_eof),
    .mark      (mark)
  );

  egm_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_data (push_data),
    .push_sof  (push_sof),
    .push_eof  (push_eof),
    .mark      (mark),
    .push_ok   (push_ok),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

endmodule

// File: rtl/egm_checks.sv
module egm_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof
);

  logic mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mid_q <= 1'b0;
    else if (out_valid && out_ready) mid_q <= !out_eof;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sof) && $stable(out_eof)));

  assert_sof_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mid_q) |-> out_sof);

  assert_sof_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mid_q) |-> !out_sof);

endmodule

bind egress_editor egm_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof)
);

// File: tb/egress_editor_test.sv
`timescale 1ns/1ps
module egress_editor_test;

  typedef struct packed {
    logic [7:0] c0, c1, c2, c3;
    logic [2:0] n;
    logic [5:0] len;
    logic [6:0] hand_n;
  } vec_t;

  // c0..c3, command count, frame length, hand-counted output length
  localparam vec_t VECS [12] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 6'd8, 7'd8},  // R10 no commands
    '{8'h02, 8'h23, 8'h00, 8'h00, 3'd2, 6'd8, 7'd11}, // R3 copy, R4 insert
    '{8'h43, 8'h00, 8'h00, 8'h00, 3'd1, 6'd8, 7'd5},  // R5 drop
    '{8'h02, 8'h82, 8'hA0, 8'h00, 3'd3, 6'd8, 7'd8},  // R7 decrement, R8 checksum
    '{8'h22, 8'h61, 8'h40, 8'h00, 3'd3, 6'd6, 7'd7},  // R6 replace, R9 operand order
    '{8'h03, 8'h45, 8'h00, 8'h00, 3'd2, 6'd6, 7'd3},  // R11 last byte dropped
    '{8'h48, 8'h00, 8'h00, 8'h00, 3'd1, 6'd4, 7'd0},  // R11 empty frame
    '{8'h1F, 8'h22, 8'h00, 8'h00, 3'd2, 6'd5, 7'd5},  // R10 leftover discarded
    '{8'hE2, 8'h40, 8'h00, 8'h00, 3'd2, 6'd4, 7'd3},  // R2 reserved opcode
    '{8'h21, 8'h00, 8'h00, 8'h00, 3'd1, 6'd1, 7'd2},  // R4 one-byte frame
    '{8'h60, 8'h00, 8'h00, 8'h00, 3'd1, 6'd3, 7'd3},  // R2 count zero
    '{8'h65, 8'hA7, 8'h00, 8'h00, 3'd2, 6'd8, 7'd8}   // R8 count ignored
  };

  logic       clk, rst_n;
  logic       cfg_cmd_we, cfg_len_we, cfg_opr_we;
  logic [4:0] cfg_cmd_addr, cfg_len;
  logic [7:0] cfg_cmd_data, cfg_opr_data;
  logic [5:0] cfg_opr_addr;
  logic       in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_sof, out_eof;
  logic [7:0] out_data;

  egress_editor uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cmd_we(cfg_cmd_we), .cfg_cmd_addr(cfg_cmd_addr), .cfg_cmd_data(cfg_cmd_data),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .cfg_opr_we(cfg_opr_we), .cfg_opr_addr(cfg_opr_addr), .cfg_opr_data(cfg_opr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] exp_b [128];
  int         exp_n;
  logic [7:0] got_b [128];
  logic       got_sof [128];
  logic       got_eof [128];
  int         got_n;
  logic       hold_bad;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] inb(input int i);
    if (i == 2) return 8'h00;
    if (i == 3) return 8'h01;
    return 8'(8'h10 + i);
  endfunction

  function automatic logic [7:0] opv(input int k);
    return (k < 56) ? 8'(8'hA0 + k) : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // reference stream built from the requirements
  task automatic model(input logic [7:0] c [4], input int n, input int len);
    int ip, op;
    ip = 0; op = 0; exp_n = 0;
    for (int ci = 0; ci < n; ci++) begin
      int cnt, opc;
      opc = int'(c[ci][7:5]);
      cnt = (c[ci][4:0] == 5'd0) ? 1 : int'(c[ci][4:0]);
      if (opc == 5) cnt = 2;
      for (int j = 0; j < cnt; j++) begin
        if (ip < len) begin
          case (opc)
            1: begin exp_b[exp_n] = opv(op); op++; exp_n++; end
            2: ip++;
            3, 5: begin exp_b[exp_n] = opv(op); op++; ip++; exp_n++; end
            4: begin
              exp_b[exp_n] = (inb(ip) == 8'h00) ? 8'h00 : inb(ip) - 8'h01;
              ip++; exp_n++;
            end
            default: begin exp_b[exp_n] = inb(ip); ip++; exp_n++; end
          endcase
        end
      end
    end
    while (ip < len) begin exp_b[exp_n] = inb(ip); ip++; exp_n++; end
  endtask

  task automatic load_cmds(input logic [7:0] c [4], input int n);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cfg_cmd_we = 1'b1; cfg_cmd_addr = 5'(i); cfg_cmd_data = c[i];
    end
    @(negedge clk);
    cfg_cmd_we = 1'b0; cfg_len_we = 1'b1; cfg_len = 5'(n);
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = inb(i);
      in_sof = (i == 0); in_eof = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic collect();
    int idle;
    logic done, prev_stall;
    logic [7:0] prev_d;
    logic prev_s, prev_e;
    idle = 0; done = 1'b0; got_n = 0; hold_bad = 1'b0; prev_stall = 1'b0;
    prev_d = 8'h00; prev_s = 1'b0; prev_e = 1'b0;
    while (!done && idle < 60) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (prev_stall && !(out_valid && out_data == prev_d &&
                          out_sof == prev_s && out_eof == prev_e))
        hold_bad = 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_s = out_sof; prev_e = out_eof;
      if (out_valid && out_ready && got_n < 128) begin
        got_b[got_n] = out_data; got_sof[got_n] = out_sof; got_eof[got_n] = out_eof;
        got_n++; idle = 0;
        if (out_eof) done = 1'b1;
      end else begin
        idle++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_case(input logic [7:0] c [4], input int n, input int len,
                          input int hand_n, input string tag);
    int bad_at;
    logic flags_ok;
    load_cmds(c, n);
    model(c, n, len);
    fork
      send_frame(len);
      collect();
    join
    chk(got_n == hand_n && exp_n == hand_n, {tag, " length"}, got_n, hand_n);
    bad_at = -1;
    for (int i = 0; i < got_n && i < exp_n; i++)
      if (bad_at < 0 && got_b[i] != exp_b[i]) bad_at = i;
    if (bad_at >= 0) chk(1'b0, {tag, " data"}, int'(got_b[bad_at]), int'(exp_b[bad_at]));
    else             chk(1'b1, {tag, " data"}, 0, 0);
    flags_ok = 1'b1;
    for (int i = 0; i < got_n; i++) begin
      if (got_sof[i] != (i == 0)) flags_ok = 1'b0;
      if (got_eof[i] != (i == got_n - 1)) flags_ok = 1'b0;
    end
    chk(flags_ok, {tag, " R11 markers"}, int'(flags_ok), 1);
    if (bp_en) chk(!hold_bad, {tag, " R12 held output"}, int'(hold_bad), 0);
  endtask

  initial begin
    logic [7:0] cv [4];
    logic ok;
    rst_n = 1'b0;
    cfg_cmd_we = 1'b0; cfg_len_we = 1'b0; cfg_opr_we = 1'b0;
    cfg_cmd_addr = '0; cfg_len = '0; cfg_cmd_data = '0;
    cfg_opr_addr = '0; cfg_opr_data = '0;
    in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    out_ready = 1'b1;

    // R1 reset state
    repeat (3) @(negedge clk);
    #1 chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(!out_valid && in_ready, "R1 idle after reset", int'({out_valid, in_ready}), 1);

    // operand buffer, R9: operand k = 0xA0 + k
    for (int k = 0; k < 56; k++) begin
      @(negedge clk);
      cfg_opr_we = 1'b1; cfg_opr_addr = 6'(k); cfg_opr_data = 8'(8'hA0 + k);
    end
    @(negedge clk);
    cfg_opr_we = 1'b0;

    // table walk, first with a free sink and then with a throttled one (R12)
    for (int pass = 0; pass < 2; pass++) begin
      bp_en = (pass == 1);
      for (int v = 0; v < 12; v++) begin
        cv[0] = VECS[v].c0; cv[1] = VECS[v].c1; cv[2] = VECS[v].c2; cv[3] = VECS[v].c3;
        run_case(cv, int'(VECS[v].n), int'(VECS[v].len), int'(VECS[v].hand_n),
                 $sformatf("vector %0d pass %0d", v, pass));
      end
    end
    bp_en = 1'b0;

    // R9 operands past the buffer read as zero: two inserts of 31
    cv[0] = 8'h3F; cv[1] = 8'h3F; cv[2] = 8'h00; cv[3] = 8'h00;
    run_case(cv, 2, 2, 64, "R9 operand overrun");
    chk(got_b[60] == 8'h00 && got_b[55] == 8'hD7, "R9 zero fill",
        int'(got_b[60]), 0);

    // R4 input stalled for every insert cycle
    cv[0] = 8'h23; cv[1] = 8'h00;
    load_cmds(cv, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h10; in_sof = 1'b1; in_eof = 1'b1;
    #1 ok = !in_ready;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); #1;
      if (in_ready) ok = 1'b0;
    end
    chk(ok, "R4 ready low during insert", int'(ok), 1);
    @(negedge clk); #1;
    chk(in_ready, "R4 ready returns after insert", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (8) @(negedge clk);

    // R13 stray bytes while idle are swallowed
    ok = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h55; in_sof = 1'b0; in_eof = 1'b0;
      #1 if (!in_ready) ok = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(ok, "R13 stray bytes accepted", int'(ok), 1);
    cv[0] = 8'h00;
    run_case(cv, 0, 3, 3, "R13 stray bytes absent from output");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule